// File: doc/BRIEF.md
# Brightness, contrast and saturation pixel processor

This block takes one pixel per clock: a luma sample and two colour-difference samples, Cb and Cr, each an unsigned 8-bit code with 128 as the zero point for the colour-difference pair. Luma is scaled by a contrast factor and then shifted by a brightness offset. Each colour-difference component is scaled in turn by a shared chroma gain, by a fixed per-component matching factor, and by a shared saturation factor. The matching factors differ between Cb and Cr, so that both land on the BT.601 levels. All three results are clipped to the code range 1 to 254.

The four control settings are plain inputs. They are meant to be static while pixels are in flight; each one is sampled in the pipeline stage that uses it. A valid strobe travels with the pixel. Every accepted pixel appears on the outputs exactly three clock edges later. Pipeline registers load only when their stage holds a valid pixel, so the outputs keep the last result between pixels.

Top module: `bcs_proc`

## Requirements
- R1: valid_o is valid_i delayed by exactly three rising clock edges. A pixel accepted with valid_i high at edge k appears on the outputs after edge k+2, which is the third edge counting k.
- R2: Luma output = clip(floor(y_i * contrast_i / 64) + bright_i - 128). Contrast 64 is unity, and bright_i 128 adds nothing.
- R3: Each colour-difference output is computed as follows, with every division by 64 rounding toward minus infinity: d = c - 128, t1 = floor(d * cgain_i / 64), t2 = floor(t1 * M / 64), t3 = floor(t2 * sat_i / 64), out = clip(t3 + 128). M is 73 for Cb and 52 for Cr.
- R4: clip() limits the value to the range 1 to 254. With valid_o high, no output is ever 0 or 255.
- R5: A colour-difference input of 128 gives an output of 128, whatever the gain and saturation.
- R6: With contrast_i 64 and bright_i 128, the luma output equals the input for codes 1 to 254. Input 0 gives 1 and input 255 gives 254.
- R7: With sat_i 0, both colour-difference outputs are 128.
- R8: After reset, valid_o, y_o, cb_o and cr_o are all 0. While no valid pixel reaches the last stage, the outputs hold their previous values, even if the inputs and settings change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pixel strobe |
| y_i | input | 8 | Luma in |
| cb_i | input | 8 | Blue colour-difference in, offset by 128 |
| cr_i | input | 8 | Red colour-difference in, offset by 128 |
| contrast_i | input | 8 | Luma gain, 64 = 1.0 |
| bright_i | input | 8 | Luma offset, 128 = none |
| sat_i | input | 8 | Saturation gain, 64 = 1.0 |
| cgain_i | input | 8 | Chroma gain, 64 = 1.0 |
| valid_o | output | 1 | Output pixel strobe |
| y_o | output | 8 | Luma out |
| cb_o | output | 8 | Cb out |
| cr_o | output | 8 | Cr out |

## Verification
The bench targets the clip edges from both sides:
- Luma 0 and 255 at unity settings, and an offset of one code past 254. A design clipping to 0..255 would pass these codes through unchanged.
- Negative colour-difference values whose products do not divide evenly by 64. A design that truncated toward zero would land one code high.
- Swapped or shared matching factors would show as equal Cb and Cr results for mirrored inputs.

A gapped back-to-back stream exposes a wrong pipeline depth and a valid strobe out of step with the data. Idle cycles with changing inputs expose registers that load without a valid pixel.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int DATA_W    = 8;
  localparam int FRAC_W    = 6;
  localparam int ACC_W     = 32;
  localparam int CODE_MID  = 1 << (DATA_W - 1);
  localparam int CODE_MIN  = 1;
  localparam int CODE_MAX  = (1 << DATA_W) - 2;
  localparam int CB_MATCH  = 73;
  localparam int CR_MATCH  = 52;

  function automatic logic [DATA_W-1:0] clip_code(input logic signed [ACC_W-1:0] v);
    if (v < ACC_W'(CODE_MIN))      return DATA_W'(CODE_MIN);
    else if (v > ACC_W'(CODE_MAX)) return DATA_W'(CODE_MAX);
    else                           return v[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/bcs_luma_path.sv
module bcs_luma_path
  import bcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        en_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [DATA_W-1:0] contrast_i,
  input  logic [DATA_W-1:0] bright_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0]       prod_q;
  logic signed [ACC_W-1:0] sum_q;
  logic signed [ACC_W-1:0] sum_d;

  always_comb begin
    sum_d = signed'(ACC_W'(prod_q >> FRAC_W)) + signed'(ACC_W'(bright_i))
            - signed'(ACC_W'(CODE_MID));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      sum_q  <= '0;
      y_o    <= '0;
    end else begin
      if (en_i[0]) prod_q <= PROD_W'(y_i) * PROD_W'(contrast_i);
      if (en_i[1]) sum_q  <= sum_d;
      if (en_i[2]) y_o    <= clip_code(sum_q);
    end
  end

  // R8
  luma_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i[2] |=> $stable(y_o));
endmodule

// File: rtl/bcs_chroma_path.sv
module bcs_chroma_path
  import bcs_pkg::*;
#(
  parameter int MATCH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        en_i,
  input  logic [DATA_W-1:0] c_i,
  input  logic [DATA_W-1:0] cgain_i,
  input  logic [DATA_W-1:0] sat_i,
  output logic [DATA_W-1:0] c_o
);
  localparam logic signed [ACC_W-1:0] MATCH_S = ACC_W'(MATCH);
  localparam logic signed [ACC_W-1:0] MID_S   = ACC_W'(CODE_MID);

  logic signed [ACC_W-1:0] diff, gain_s, sat_s;
  logic signed [ACC_W-1:0] agc_q, match_q, sat_d;

  always_comb begin
    diff   = signed'(ACC_W'(c_i)) - MID_S;
    gain_s = signed'(ACC_W'(cgain_i));
    sat_s  = signed'(ACC_W'(sat_i));
    sat_d  = ((match_q * sat_s) >>> FRAC_W) + MID_S;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      agc_q   <= '0;
      match_q <= '0;
      c_o     <= '0;
    end else begin
      if (en_i[0]) agc_q   <= (diff * gain_s) >>> FRAC_W;
      if (en_i[1]) match_q <= (agc_q * MATCH_S) >>> FRAC_W;
      if (en_i[2]) c_o     <= clip_code(sat_d);
    end
  end

  // R8
  chroma_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i[2] |=> $stable(c_o));
  // R5
  zero_diff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i[0] && c_i == DATA_W'(CODE_MID) |=> agc_q == '0);
endmodule

// File: rtl/bcs_proc.sv
module bcs_proc
  import bcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [DATA_W-1:0] cb_i,
  input  logic [DATA_W-1:0] cr_i,
  input  logic [DATA_W-1:0] contrast_i,
  input  logic [DATA_W-1:0] bright_i,
  input  logic [DATA_W-1:0] sat_i,
  input  logic [DATA_W-1:0] cgain_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] y_o,
  output logic [DATA_W-1:0] cb_o,
  output logic [DATA_W-1:0] cr_o
);
  localparam int STAGES = 3;
  localparam int NCOMP  = 2;

  logic [STAGES-1:0]             vld_q;
  logic [STAGES-1:0]             stage_en;
  logic [NCOMP-1:0][DATA_W-1:0]  c_in;
  logic [NCOMP-1:0][DATA_W-1:0]  c_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[STAGES-2:0], valid_i};
  end

  assign stage_en = {vld_q[STAGES-2:0], valid_i};
  assign valid_o  = vld_q[STAGES-1];
  assign c_in     = {cr_i, cb_i};
  assign cb_o     = c_out[0];
  assign cr_o     = c_out[1];

  bcs_luma_path u_luma (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (stage_en),
    .y_i        (y_i),
    .contrast_i (contrast_i),
    .bright_i   (bright_i),
    .y_o        (y_o)
  );

  for (genvar k = 0; k < NCOMP; k++) begin : g_chroma
    bcs_chroma_path #(
      .MATCH ((k == 0) ? CB_MATCH : CR_MATCH)
    ) u_chroma (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (stage_en),
      .c_i     (c_in[k]),
      .cgain_i (cgain_i),
      .sat_i   (sat_i),
      .c_o     (c_out[k])
    );
  end

  // R1
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i, 3));
  // R4
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (y_o >= DATA_W'(CODE_MIN) && y_o <= DATA_W'(CODE_MAX) &&
                 cb_o >= DATA_W'(CODE_MIN) && cb_o <= DATA_W'(CODE_MAX) &&
                 cr_o >= DATA_W'(CODE_MIN) && cr_o <= DATA_W'(CODE_MAX)));
  // R5
  neutral_cb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(cb_i, 3) == DATA_W'(CODE_MID) |-> cb_o == DATA_W'(CODE_MID));
  // R7
  sat_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(sat_i) == '0 |-> cb_o == DATA_W'(CODE_MID) && cr_o == DATA_W'(CODE_MID));
endmodule

// File: tb/tb_bcs_proc.sv
module tb_bcs_proc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] y_i = '0, cb_i = 8'd128, cr_i = 8'd128;
  logic [7:0] contrast_i = 8'd64, bright_i = 8'd128, sat_i = 8'd64, cgain_i = 8'd64;
  logic       valid_o;
  logic [7:0] y_o, cb_o, cr_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  bcs_proc dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .y_i(y_i), .cb_i(cb_i), .cr_i(cr_i),
    .contrast_i(contrast_i), .bright_i(bright_i), .sat_i(sat_i), .cgain_i(cgain_i),
    .valid_o(valid_o), .y_o(y_o), .cb_o(cb_o), .cr_o(cr_o)
  );

  // {y, cb, cr, contrast, bright, sat, cgain, exp_y, exp_cb, exp_cr}
  localparam int NV = 11;
  localparam logic [79:0] VEC [NV] = '{
    {8'd100, 8'd200, 8'd200, 8'd64,  8'd128, 8'd64,  8'd64,  8'd100, 8'd210, 8'd186},
    {8'd100, 8'd56,  8'd56,  8'd64,  8'd128, 8'd64,  8'd64,  8'd100, 8'd45,  8'd69 },
    {8'd0,   8'd128, 8'd128, 8'd64,  8'd128, 8'd64,  8'd64,  8'd1,   8'd128, 8'd128},
    {8'd255, 8'd255, 8'd0,   8'd64,  8'd128, 8'd64,  8'd64,  8'd254, 8'd254, 8'd24 },
    {8'd100, 8'd250, 8'd10,  8'd128, 8'd128, 8'd0,   8'd64,  8'd200, 8'd128, 8'd128},
    {8'd100, 8'd140, 8'd120, 8'd64,  8'd200, 8'd64,  8'd128, 8'd172, 8'd155, 8'd115},
    {8'd100, 8'd192, 8'd64,  8'd64,  8'd0,   8'd32,  8'd64,  8'd1,   8'd164, 8'd102},
    {8'd200, 8'd128, 8'd128, 8'd0,   8'd128, 8'd64,  8'd64,  8'd1,   8'd128, 8'd128},
    {8'd255, 8'd129, 8'd127, 8'd255, 8'd255, 8'd255, 8'd255, 8'd254, 8'd139, 8'd112},
    {8'd1,   8'd129, 8'd127, 8'd64,  8'd128, 8'd64,  8'd64,  8'd1,   8'd129, 8'd127},
    {8'd254, 8'd128, 8'd128, 8'd64,  8'd129, 8'd64,  8'd64,  8'd254, 8'd128, 8'd128}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clip(input int v);
    return (v < 1) ? 1 : (v > 254) ? 254 : v;
  endfunction

  function automatic int mdl_y(input int y, input int con, input int bri);
    return clip(((y * con) >>> 6) + bri - 128);
  endfunction

  function automatic int mdl_c(input int c, input int cg, input int m, input int sat);
    int t;
    t = ((c - 128) * cg) >>> 6;
    t = (t * m) >>> 6;
    t = (t * sat) >>> 6;
    return clip(t + 128);
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset valid_o", int'(valid_o), 0);
    chk("R8 reset y_o", int'(y_o), 0);
    chk("R8 reset cb_o", int'(cb_o), 0);
    chk("R8 reset cr_o", int'(cr_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 R6 R7, R1 timing, R8 hold
    for (int i = 0; i < NV; i++) begin
      {y_i, cb_i, cr_i, contrast_i, bright_i, sat_i, cgain_i} = VEC[i][79:24];
      valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
      chk("R1 early valid_o", int'(valid_o), 0);
      @(negedge clk);
      chk("R1 early valid_o", int'(valid_o), 0);
      @(negedge clk);
      chk("R1 valid_o at latency 3", int'(valid_o), 1);
      chk("R2 R6 luma", int'(y_o), int'(VEC[i][23:16]));
      chk("R3 R5 cb", int'(cb_o), int'(VEC[i][15:8]));
      chk("R3 R7 cr", int'(cr_o), int'(VEC[i][7:0]));
      y_i = 8'd7; cb_i = 8'd3; cr_i = 8'd250; contrast_i = 8'd200; sat_i = 8'd9;
      @(negedge clk);
      chk("R1 valid_o drops", int'(valid_o), 0);
      chk("R8 hold y", int'(y_o), int'(VEC[i][23:16]));
      chk("R8 hold cb", int'(cb_o), int'(VEC[i][15:8]));
    end

    // R8: idle cycles with changing inputs and settings leave outputs alone
    for (int k = 0; k < 5; k++) begin
      y_i = 8'(k * 37); cb_i = 8'(k * 51); cr_i = 8'(255 - k * 40);
      bright_i = 8'(k * 60); cgain_i = 8'(k * 20);
      @(negedge clk);
    end
    chk("R8 idle y", int'(y_o), int'(VEC[NV-1][23:16]));
    chk("R8 idle cr", int'(cr_o), int'(VEC[NV-1][7:0]));
    chk("R8 idle valid_o", int'(valid_o), 0);

    // R1 R3: gapped back-to-back stream
    contrast_i = 8'd80; bright_i = 8'd120; sat_i = 8'd70; cgain_i = 8'd90;
    begin
      bit vl [16];
      int ey [16], ecb [16], ecr [16];
      for (int n = 0; n < 16; n++) begin
        if (n >= 3) begin
          chk("R1 stream valid_o", int'(valid_o), int'(vl[n-3]));
          if (vl[n-3]) begin
            chk("R2 stream y", int'(y_o), ey[n-3]);
            chk("R3 stream cb", int'(cb_o), ecb[n-3]);
            chk("R3 stream cr", int'(cr_o), ecr[n-3]);
          end
        end
        vl[n]   = (n < 11) && (n != 4) && (n != 7);
        y_i     = 8'(20 + n * 19);
        cb_i    = 8'(n * 23 + 5);
        cr_i    = 8'(250 - n * 21);
        ey[n]   = mdl_y(int'(y_i), 80, 120);
        ecb[n]  = mdl_c(int'(cb_i), 90, 73, 70);
        ecr[n]  = mdl_c(int'(cr_i), 90, 52, 70);
        valid_i = vl[n];
        @(negedge clk);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule